// File: doc/BRIEF.md
# Load Instruction Fetch and Cycle Sequencer

This block is the control core of a small 8-bit processor that executes one kind of memory operation: loading the accumulator, in any of eight addressing modes. It also executes a single-byte instruction that clears the carry flag. It drives a 16-bit address bus and reads 8-bit data from it. The data for an address must be presented within the same clock cycle. Every cycle performs exactly one bus read, including the filler cycles.

Each instruction starts with an opcode read at the program counter, and that cycle is flagged on `sync`. The opcode is split into a row nibble and a column nibble. A decode lookup uses them to choose the addressing mode and the base cycle budget. The sequencer then steps through a short per-mode micro-sequence. It collects operand bytes, forms the effective address, loads the accumulator and updates the negative and zero flags. The instruction ends when the cycle budget is spent. Indexed modes extend the budget by one cycle only when the index addition carries into the high address byte. An opcode outside the supported set stops the core.

Top module: `ldseq_core`

## Requirements
- R1: While `rst_n` is low, the state resets as follows. PC takes `RST_PC` (default 0x0200), A takes 0x00, X takes `RST_X` (default 0x05), Y takes `RST_Y` (default 0xF0) and status takes `RST_P` (default 0x25). `halted` is low, and the first cycle after reset is an opcode fetch with `sync` high.
- R2: `sync` is high exactly in opcode-fetch cycles, and in those cycles `mem_addr` equals `reg_pc`. Two fetch cycles are never adjacent.
- R3: The opcode decodes as row = bits 7:4 and column = bits 3:0. The supported opcodes are 0xA9, 0xA5, 0xB5, 0xAD, 0xBD, 0xB9, 0xA1, 0xB1 and 0x18. PC advances by the instruction length (1, 2 or 3 bytes), at most one per cycle.
- R4: Opcode 0xA9 (immediate) loads the byte that follows the opcode. It is 2 bytes long and takes 2 cycles.
- R5: Opcode 0xA5 (zero page) loads from 0x00nn and takes 3 cycles. Opcode 0xB5 (zero page indexed by X) loads from 0x00((nn+X) mod 256) and takes 4 cycles. Both are 2 bytes long.
- R6: Opcode 0xAD (absolute) takes its address low byte first, is 3 bytes long and takes 4 cycles.
- R7: Opcodes 0xBD and 0xB9 (absolute indexed by X or by Y) load from (address + index) mod 65536 and are 3 bytes long. They take 4 cycles, or 5 when the low-byte sum carries. The final bus read is at the effective address.
- R8: Opcode 0xA1 (pre-indexed indirect) forms q = (nn+X) mod 256. It reads the pointer low byte at 0x00q and the high byte at 0x00((q+1) mod 256), then loads from the pointer. It is 2 bytes long and takes 6 cycles.
- R9: Opcode 0xB1 (post-indexed indirect) reads the pointer at 0x00nn and 0x00((nn+1) mod 256), adds Y, and loads from the result mod 65536. It is 2 bytes long and takes 5 cycles, or 6 when the low-byte sum carries.
- R10: A load writes A and sets status bit 7 (N) to bit 7 of the value and status bit 1 (Z) to (value == 0). All other status bits, including bit 0 (C), are left unchanged.
- R11: Opcode 0x18 is 1 byte long and takes 2 cycles. It clears status bit 0 only and leaves A unchanged.
- R12: An unsupported opcode sets `halted`. From then on, `sync` stays low and PC stays at the unsupported opcode. Only reset clears `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Address of this cycle's bus read |
| mem_rdata | input | 8 | Data at `mem_addr`, valid in the same cycle |
| sync | output | 1 | High during opcode-fetch cycles |
| halted | output | 1 | Sticky stop on an unsupported opcode |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | X index register |
| reg_y | output | 8 | Y index register |
| reg_pc | output | 16 | Program counter |
| status | output | 8 | Status flags (bit 7 N, bit 1 Z, bit 0 C) |

## Verification
The program walks every addressing mode with several operands, and the operands are chosen to separate specific faults:
- Immediate values of 0x00, 0x80, 0x7F, 0x01 and 0xFF separate the negative and zero flag logic.
- Zero-page and pointer operands near 0xFF check that address sums wrap inside page zero rather than spilling into page one.
- Indexed bases placed on each side of a page boundary, including 0xFFFB, tell the 4- and 5-cycle paths apart, and likewise the 5- and 6-cycle paths. They also check the high-byte fix-up and the wrap of the full 16-bit address.
- The clear-carry instruction sits between loads, so carry retention is checked both set and clear, and a trailing unsupported opcode checks the stop.

// File: rtl/ldseq_pkg.sv
// Package ldseq_pkg
// Shared types for the load sequencer: addressing modes, micro-steps,
// the decode record and the status bit positions.
// Assumes an 8-bit data path and a 16-bit address.
package ldseq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2 * DATA_W;
    localparam int unsigned CNT_W  = 4;

    localparam int unsigned ST_N = 7;
    localparam int unsigned ST_Z = 1;
    localparam int unsigned ST_C = 0;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [3:0] {
        AM_IMM, AM_ZP, AM_ZPX, AM_ABS, AM_ABSX, AM_ABSY,
        AM_INDX, AM_INDY, AM_IMPL
    } amode_e;

    typedef enum logic [3:0] {
        U_FETCH, U_LOAD_PC, U_GET_PTR, U_ADD_PTR, U_LOAD_ZP,
        U_GET_LO, U_GET_HI, U_PTR_LO, U_PTR_HI, U_IDX_TRY,
        U_LOAD_EA, U_CLR_C, U_WAIT
    } uop_e;

    typedef struct packed {
        logic   valid;
        amode_e mode;
        cnt_t   cycles;
    } dec_t;

endpackage

// File: rtl/ldseq_decode.sv
// Module ldseq_decode
// Splits the opcode into a row nibble and a column nibble and looks up
// the addressing mode and base cycle budget.
// Assumes: purely combinational; rows 0xA/0xB hold the load family,
// the odd row selects the indexed variant of each column.
module ldseq_decode
    import ldseq_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output dec_t              dec
);

    localparam logic [3:0] LOAD_ROW_HI = 4'hA;
    localparam logic [3:0] CLC_ROW     = 4'h1;
    localparam logic [3:0] CLC_COL     = 4'h8;

    logic [3:0] row;
    logic [3:0] col;
    logic       load_row;
    logic       odd_row;

    assign row      = opcode[7:4];
    assign col      = opcode[3:0];
    assign load_row = (row[3:1] == LOAD_ROW_HI[3:1]);
    assign odd_row  = row[0];

    // Purpose: table lookup indexed by row and column.
    always_comb begin
        dec.valid  = 1'b0;
        dec.mode   = AM_IMPL;
        dec.cycles = cnt_t'(2);
        if (load_row) begin
            case (col)
                4'h1: begin
                    dec.valid  = 1'b1;
                    dec.mode   = odd_row ? AM_INDY : AM_INDX;
                    dec.cycles = odd_row ? cnt_t'(5) : cnt_t'(6);
                end
                4'h5: begin
                    dec.valid  = 1'b1;
                    dec.mode   = odd_row ? AM_ZPX : AM_ZP;
                    dec.cycles = odd_row ? cnt_t'(4) : cnt_t'(3);
                end
                4'h9: begin
                    dec.valid  = 1'b1;
                    dec.mode   = odd_row ? AM_ABSY : AM_IMM;
                    dec.cycles = odd_row ? cnt_t'(4) : cnt_t'(2);
                end
                4'hD: begin
                    dec.valid  = 1'b1;
                    dec.mode   = odd_row ? AM_ABSX : AM_ABS;
                    dec.cycles = cnt_t'(4);
                end
                default: ;
            endcase
        end else if (row == CLC_ROW && col == CLC_COL) begin
            dec.valid  = 1'b1;
            dec.mode   = AM_IMPL;
            dec.cycles = cnt_t'(2);
        end
    end

endmodule

// File: rtl/ldseq_idxadd.sv
// Module ldseq_idxadd
// Adds an index to the low address byte and reports the carry that
// marks a page crossing.
// Assumes: combinational; the caller fixes up the high byte.
module ldseq_idxadd #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] base_lo,
    input  logic [W-1:0] index,
    output logic [W-1:0] sum_lo,
    output logic         carry
);

    // Purpose: one W-bit addition with carry out.
    assign {carry, sum_lo} = {1'b0, base_lo} + {1'b0, index};

endmodule

// File: rtl/ldseq_core.sv
// Module ldseq_core
// Multi-cycle sequencer for accumulator loads in eight addressing modes
// plus clear-carry. One bus read per cycle; the read data must arrive
// in the same cycle. A step counter and the latched mode select a
// micro-step; the instruction ends when the step count meets the budget
// from decode plus one for a page crossing.
// Assumes: synchronous active-low reset; X and Y are fixed at reset.
module ldseq_core
    import ldseq_pkg::*;
#(
    parameter logic [15:0] RST_PC = 16'h0200,
    parameter logic [7:0]  RST_X  = 8'h05,
    parameter logic [7:0]  RST_Y  = 8'hF0,
    parameter logic [7:0]  RST_P  = 8'h25
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        sync,
    output logic        halted,
    output logic [7:0]  reg_a,
    output logic [7:0]  reg_x,
    output logic [7:0]  reg_y,
    output logic [15:0] reg_pc,
    output logic [7:0]  status
);

    localparam logic [DATA_W-1:0] ZP_PAGE = '0;

    cnt_t              step_q;
    cnt_t              base_q;
    amode_e            mode_q;
    logic              extra_q;
    logic              halted_q;
    logic [DATA_W-1:0] ptr_q, lo_q, hi_q;
    logic [DATA_W-1:0] a_q, x_q, y_q, p_q;
    logic [ADDR_W-1:0] pc_q;

    dec_t              dec;
    uop_e              uop;
    logic [DATA_W-1:0] idx_sel, sum_lo, ptr_next;
    logic              carry, cross_now, load_now, pc_inc, done;

    ldseq_decode u_decode (
        .opcode (mem_rdata),
        .dec    (dec)
    );

    assign idx_sel = (mode_q == AM_ABSX) ? x_q : y_q;

    ldseq_idxadd #(.W(DATA_W)) u_idxadd (
        .base_lo (lo_q),
        .index   (idx_sel),
        .sum_lo  (sum_lo),
        .carry   (carry)
    );

    // Purpose: pick this cycle's micro-step from mode and step count.
    always_comb begin
        uop = U_WAIT;
        if (step_q == '0) begin
            uop = U_FETCH;
        end else begin
            case (mode_q)
                AM_IMM:  if (step_q == cnt_t'(1)) uop = U_LOAD_PC;
                AM_IMPL: if (step_q == cnt_t'(1)) uop = U_CLR_C;
                AM_ZP:
                    case (step_q)
                        cnt_t'(1): uop = U_GET_PTR;
                        cnt_t'(2): uop = U_LOAD_ZP;
                        default:   ;
                    endcase
                AM_ZPX:
                    case (step_q)
                        cnt_t'(1): uop = U_GET_PTR;
                        cnt_t'(2): uop = U_ADD_PTR;
                        cnt_t'(3): uop = U_LOAD_ZP;
                        default:   ;
                    endcase
                AM_ABS:
                    case (step_q)
                        cnt_t'(1): uop = U_GET_LO;
                        cnt_t'(2): uop = U_GET_HI;
                        cnt_t'(3): uop = U_LOAD_EA;
                        default:   ;
                    endcase
                AM_ABSX, AM_ABSY:
                    case (step_q)
                        cnt_t'(1): uop = U_GET_LO;
                        cnt_t'(2): uop = U_GET_HI;
                        cnt_t'(3): uop = U_IDX_TRY;
                        cnt_t'(4): uop = U_LOAD_EA;
                        default:   ;
                    endcase
                AM_INDX:
                    case (step_q)
                        cnt_t'(1): uop = U_GET_PTR;
                        cnt_t'(2): uop = U_ADD_PTR;
                        cnt_t'(3): uop = U_PTR_LO;
                        cnt_t'(4): uop = U_PTR_HI;
                        cnt_t'(5): uop = U_LOAD_EA;
                        default:   ;
                    endcase
                AM_INDY:
                    case (step_q)
                        cnt_t'(1): uop = U_GET_PTR;
                        cnt_t'(2): uop = U_PTR_LO;
                        cnt_t'(3): uop = U_PTR_HI;
                        cnt_t'(4): uop = U_IDX_TRY;
                        cnt_t'(5): uop = U_LOAD_EA;
                        default:   ;
                    endcase
                default: ;
            endcase
        end
    end

    assign ptr_next = ptr_q + 8'd1;

    // Purpose: drive the bus address for the current micro-step.
    always_comb begin
        case (uop)
            U_ADD_PTR, U_LOAD_ZP, U_PTR_LO: mem_addr = {ZP_PAGE, ptr_q};
            U_PTR_HI:                       mem_addr = {ZP_PAGE, ptr_next};
            U_IDX_TRY:                      mem_addr = {hi_q, sum_lo};
            U_LOAD_EA:                      mem_addr = {hi_q, lo_q};
            default:                        mem_addr = pc_q;
        endcase
    end

    assign cross_now = (uop == U_IDX_TRY) && carry;
    assign load_now  = (uop == U_LOAD_PC) || (uop == U_LOAD_ZP) ||
                       (uop == U_LOAD_EA) || ((uop == U_IDX_TRY) && !carry);
    assign pc_inc    = ((uop == U_FETCH) && dec.valid) || (uop == U_LOAD_PC) ||
                       (uop == U_GET_PTR) || (uop == U_GET_LO) || (uop == U_GET_HI);
    assign done      = (step_q + cnt_t'(1)) == (base_q + cnt_t'(extra_q | cross_now));

    // Purpose: step counter, latched decode, page-cross extension, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            base_q   <= cnt_t'(2);
            mode_q   <= AM_IMPL;
            extra_q  <= 1'b0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (step_q == '0) begin
                if (dec.valid) begin
                    mode_q  <= dec.mode;
                    base_q  <= dec.cycles;
                    extra_q <= 1'b0;
                    step_q  <= cnt_t'(1);
                end else begin
                    halted_q <= 1'b1;
                end
            end else begin
                step_q <= done ? '0 : step_q + cnt_t'(1);
                if (cross_now) extra_q <= 1'b1;
            end
        end
    end

    // Purpose: advance the program counter one byte per consumed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pc_q <= RST_PC;
        else if (!halted_q && pc_inc) pc_q <= pc_q + 16'd1;
    end

    // Purpose: capture operand, pointer and address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            case (uop)
                U_GET_PTR:           ptr_q <= mem_rdata;
                U_ADD_PTR:           ptr_q <= ptr_q + x_q;
                U_GET_LO, U_PTR_LO:  lo_q  <= mem_rdata;
                U_GET_HI, U_PTR_HI:  hi_q  <= mem_rdata;
                U_IDX_TRY: if (carry) begin
                    lo_q <= sum_lo;
                    hi_q <= hi_q + 8'd1;
                end
                default: ;
            endcase
        end
    end

    // Purpose: accumulator load and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            p_q <= RST_P;
        end else if (load_now) begin
            a_q       <= mem_rdata;
            p_q[ST_N] <= mem_rdata[7];
            p_q[ST_Z] <= (mem_rdata == '0);
        end else if (uop == U_CLR_C) begin
            p_q[ST_C] <= 1'b0;
        end
    end

    // Purpose: index registers hold their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= RST_X;
            y_q <= RST_Y;
        end
    end

    assign sync   = (step_q == '0) && !halted_q;
    assign halted = halted_q;
    assign reg_a  = a_q;
    assign reg_x  = x_q;
    assign reg_y  = y_q;
    assign reg_pc = pc_q;
    assign status = p_q;

endmodule

// File: rtl/ldseq_checker.sv
// Module ldseq_checker
// Port-level temporal properties of ldseq_core, attached with bind.
// Assumes: reset is held for at least one clock edge at start.
module ldseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sync,
    input logic        halted,
    input logic [15:0] mem_addr,
    input logic [15:0] reg_pc,
    input logic [7:0]  status
);

    a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (mem_addr == reg_pc));

    a_r2_no_adjacent_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !sync);

    a_r3_pc_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_pc != $past(reg_pc)) |-> (reg_pc == $past(reg_pc) + 16'd1));

    a_r10_other_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status[6:2]));

    a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r12_halt_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !sync);

    a_r12_halt_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(reg_pc));

endmodule

bind ldseq_core ldseq_checker u_ldseq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync     (sync),
    .halted   (halted),
    .mem_addr (mem_addr),
    .reg_pc   (reg_pc),
    .status   (status)
);

// File: tb/test_ldseq_core.sv
`timescale 1ns/1ps
// Bench for ldseq_core: builds a program covering every addressing mode
// with boundary operands, then checks each instruction at the ports.
module test_ldseq_core;

    localparam logic [15:0] P_PC = 16'h0200;
    localparam logic [7:0]  P_X  = 8'h05;
    localparam logic [7:0]  P_Y  = 8'hF0;
    localparam logic [7:0]  P_P  = 8'h25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        sync, halted;
    logic [7:0]  reg_a, reg_x, reg_y, status;
    logic [15:0] reg_pc;

    int n_run = 0;
    int n_fail = 0;

    logic [7:0] ram [0:4095];

    logic [15:0] e_ea  [64];
    bit          e_ld  [64];
    int          e_cyc [64];
    int          e_len [64];
    string       e_req [64];
    int          ne = 0;
    int          wp = 32'h0200;

    always #2 clk = ~clk;

    ldseq_core #(.RST_PC(P_PC), .RST_X(P_X), .RST_Y(P_Y), .RST_P(P_P)) i_ldseq_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .sync(sync), .halted(halted), .reg_a(reg_a), .reg_x(reg_x),
        .reg_y(reg_y), .reg_pc(reg_pc), .status(status)
    );

    function automatic logic [7:0] data_at(input logic [15:0] a);
        if (a < 16'h1000) return ram[a[11:0]];
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
    endfunction

    always_comb mem_rdata = data_at(mem_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic emit(input logic [7:0] b);
        ram[wp[11:0]] = b;
        wp++;
    endtask

    task automatic add(input logic [15:0] ea, input bit ld, input int cyc,
                       input int len, input string req);
        e_ea[ne] = ea; e_ld[ne] = ld; e_cyc[ne] = cyc; e_len[ne] = len; e_req[ne] = req;
        ne++;
    endtask

    function automatic logic [15:0] zp_ptr(input logic [7:0] q);
        return {ram[{4'h0, q + 8'd1}], ram[{4'h0, q}]};
    endfunction

    task automatic build();
        logic [7:0]  imm_v [5] = '{8'h00, 8'h80, 8'h7F, 8'h01, 8'hFF};
        logic [7:0]  zp_v  [4] = '{8'h33, 8'h80, 8'hFF, 8'h00};
        logic [7:0]  zpx_v [4] = '{8'h10, 8'hFA, 8'hFD, 8'hFF};
        logic [15:0] abs_v [4] = '{16'h1234, 16'h8000, 16'hFFFF, 16'h0040};
        logic [15:0] abx_v [4] = '{16'h2010, 16'h20FE, 16'h30FA, 16'hFFFB};
        logic [15:0] aby_v [4] = '{16'h4005, 16'h4010, 16'h7F0F, 16'h90FF};
        logic [7:0]  inx_v [4] = '{8'h20, 8'hFA, 8'hF0, 8'h7E};
        logic [7:0]  iny_v [4] = '{8'h44, 8'hFF, 8'h90, 8'h0C};
        for (int i = 0; i < 4096; i++) ram[i] = (i < 256) ? 8'(i * 37 + 11) : 8'h00;
        ram[12'h033] = 8'h00;
        ram[12'h044] = 8'h05; ram[12'h045] = 8'h50;
        ram[12'h090] = 8'h20; ram[12'h091] = 8'h60;
        // R4 immediate, R10 flag patterns
        for (int k = 0; k < 5; k++) begin
            add(16'(wp + 1), 1'b1, 2, 2, "R4"); emit(8'hA9); emit(imm_v[k]);
        end
        // R5 zero page
        for (int k = 0; k < 4; k++) begin
            add({8'h00, zp_v[k]}, 1'b1, 3, 2, "R5"); emit(8'hA5); emit(zp_v[k]);
        end
        // R11 clear carry
        add(16'h0000, 1'b0, 2, 1, "R11"); emit(8'h18);
        // R5 zero page indexed, wraps in page zero
        for (int k = 0; k < 4; k++) begin
            add({8'h00, zpx_v[k] + P_X}, 1'b1, 4, 2, "R5"); emit(8'hB5); emit(zpx_v[k]);
        end
        // R6 absolute
        for (int k = 0; k < 4; k++) begin
            add(abs_v[k], 1'b1, 4, 3, "R6");
            emit(8'hAD); emit(abs_v[k][7:0]); emit(abs_v[k][15:8]);
        end
        // R7 absolute indexed by X
        for (int k = 0; k < 4; k++) begin
            add(abx_v[k] + 16'(P_X), 1'b1,
                4 + int'((abx_v[k][7:0] + 9'(P_X)) > 9'd255), 3, "R7");
            emit(8'hBD); emit(abx_v[k][7:0]); emit(abx_v[k][15:8]);
        end
        // R7 absolute indexed by Y
        for (int k = 0; k < 4; k++) begin
            add(aby_v[k] + 16'(P_Y), 1'b1,
                4 + int'((aby_v[k][7:0] + 9'(P_Y)) > 9'd255), 3, "R7");
            emit(8'hB9); emit(aby_v[k][7:0]); emit(aby_v[k][15:8]);
        end
        // R8 pre-indexed indirect
        for (int k = 0; k < 4; k++) begin
            add(zp_ptr(inx_v[k] + P_X), 1'b1, 6, 2, "R8"); emit(8'hA1); emit(inx_v[k]);
        end
        // R9 post-indexed indirect
        for (int k = 0; k < 4; k++) begin
            logic [15:0] b;
            b = zp_ptr(iny_v[k]);
            add(b + 16'(P_Y), 1'b1, 5 + int'((b[7:0] + 9'(P_Y)) > 9'd255), 2, "R9");
            emit(8'hB1); emit(iny_v[k]);
        end
        emit(8'h02);
    endtask

    task automatic run_one(input int i, inout logic [7:0] exp_a, inout logic [7:0] exp_p);
        logic [15:0] pc0, last;
        int n;
        logic [7:0] v;
        pc0 = reg_pc;
        check(sync === 1'b1 && mem_addr === pc0, "R2", "fetch address", int'(mem_addr), int'(pc0));
        n = 0;
        do begin
            last = mem_addr;
            n++;
            @(negedge clk);
        end while (!sync && n < 16);
        check(n == e_cyc[i], e_req[i], "cycle count", n, e_cyc[i]);
        check(reg_pc == 16'(pc0 + e_len[i]), "R3", "pc advance", int'(reg_pc), int'(pc0 + e_len[i]));
        if (e_ld[i]) begin
            v = data_at(e_ea[i]);
            exp_a = v;
            exp_p[7] = v[7];
            exp_p[1] = (v == 8'h00);
            check(last == e_ea[i], e_req[i], "final read address", int'(last), int'(e_ea[i]));
            check(reg_a == exp_a, e_req[i], "loaded value", int'(reg_a), int'(exp_a));
            check(status == exp_p, "R10", "status after load", int'(status), int'(exp_p));
        end else begin
            exp_p[0] = 1'b0;
            check(status == exp_p, "R11", "status after clear", int'(status), int'(exp_p));
            check(reg_a == exp_a, "R11", "accumulator kept", int'(reg_a), int'(exp_a));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R2 watchdog: actual %0d cycles expected fewer", 20000);
        finish_run();
    end

    initial begin
        logic [7:0]  exp_a, exp_p;
        logic [15:0] pc_h;
        build();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(reg_pc == P_PC, "R1", "reset pc", int'(reg_pc), int'(P_PC));
        check(reg_a == 8'h00, "R1", "reset a", int'(reg_a), 0);
        check(reg_x == P_X && reg_y == P_Y, "R1", "reset x,y", int'({reg_x, reg_y}), int'({P_X, P_Y}));
        check(status == P_P, "R1", "reset status", int'(status), int'(P_P));
        check(sync === 1'b1 && halted === 1'b0, "R1", "reset sync,halted",
              int'({sync, halted}), 2);
        exp_a = 8'h00;
        exp_p = P_P;
        for (int i = 0; i < ne; i++) run_one(i, exp_a, exp_p);
        // R12 unsupported opcode
        pc_h = reg_pc;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            check(halted === 1'b1 && sync === 1'b0, "R12", "halt state",
                  int'({halted, sync}), 2);
            check(reg_pc == pc_h, "R12", "pc frozen", int'(reg_pc), int'(pc_h));
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(halted === 1'b0 && reg_pc == P_PC, "R12", "reset clears halt",
              int'(halted), 0);
        finish_run();
    end

endmodule